// File: doc/BRIEF.md
# MSI Vector Allocation Table

This block keeps a small table that binds requesting PCI functions to contiguous ranges of message-signalled interrupt numbers. A caller sends one request at a time over a valid/ready request channel. A change request allocates a new range for a function or re-confirms the range it already has. A change request with a count of zero releases the range. A query request turns a function's local vector index into a system interrupt number. Each result comes back over a valid/ready response channel, carrying a status code and the fields that belong to the operation.

Each table slot holds a configuration address, a vector count and a base interrupt number. A count of zero marks a slot as unused. Slots fill in index order and are never emptied, so the used slots always form a prefix of the table. A bump allocator inside the block hands out base numbers. It starts at `IRQ_START` and refuses any grant that would pass `IRQ_LIMIT`. The device lookup is done outside the block: the caller reports through `req_dev_ok` whether the addressed function exists. The block itself compares the bus identifier against `OWN_BUS`.

Back-pressure rules:
- `req_ready` is high only while no response is pending. A request is taken on a clock edge where `req_valid` and `req_ready` are both high.
- The response is presented on the next cycle.
- A response stays on the port unchanged until `rsp_ready` takes it.

Top module: `msi_vec_table`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `req_ready` is 1, and the first base number granted is `IRQ_START` (256 by default).
- R2: The table is searched in index order, and the search stops at the first slot whose count is zero. A matching configuration address returns that slot. A new function is placed in the first empty slot.
- R3: A change request with count 0 for a function that has an entry returns status 0 with count 0, and the entry stays in place: a later query for that function still succeeds.
- R4: Status is a 4-bit two's-complement code: 4'h0 means success, 4'hF (-1) means a resource or state error, and 4'hD (-3) means a parameter error. Function codes 1 and 3 select MSI and return interrupt type 1. Code 4 selects MSI-X and returns type 2. Any other code gives status 4'hD.
- R5: A successful allocating change returns status 0, the requested count, the request sequence number plus one (modulo 2^`SEQ_W`), and the interrupt type. Every response field that its operation does not define is zero.
- R6: New entries receive consecutive base numbers. If the next free number plus the count would exceed `IRQ_LIMIT` (320 by default), the change returns 4'hF, no entry is created and the pool does not advance. A grant that ends exactly at the limit succeeds.
- R7: A change for a function that already has an entry succeeds without a new grant if the count is the same. If the count differs, it returns 4'hF.
- R8: A query (`req_op` = 1) returns status 0, the entry's base plus `req_vec` in `rsp_irq`, and `rsp_edge` = 1.
- R9: A query or a release for a function with no entry returns 4'hF. So does a change for a new function when every slot is used.
- R10: A bus identifier other than `OWN_BUS` (0xA5 by default) returns 4'hD for both change and query. A change with `req_dev_ok` = 0 returns 4'hD. A query ignores `req_dev_ok`.
- R11: `req_ready` equals the inverse of `rsp_valid`. The response appears in the cycle after acceptance and holds stable while `rsp_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_op | input | 1 | 0 = change/release, 1 = query |
| req_func | input | 4 | Change function code |
| req_bus | input | BUS_W | Bus identifier |
| req_dev_ok | input | 1 | External lookup found the addressed function |
| req_addr | input | ADDR_W | Function configuration address (table key) |
| req_count | input | CNT_W | Requested vector count, 0 = release |
| req_seq | input | SEQ_W | Caller sequence number |
| req_vec | input | VEC_W | Vector index for a query |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Caller takes the response |
| rsp_status | output | 4 | Status code |
| rsp_count | output | CNT_W | Granted count |
| rsp_seq | output | SEQ_W | Returned sequence number |
| rsp_itype | output | 2 | Interrupt type: 1 = MSI, 2 = MSI-X |
| rsp_irq | output | IRQ_W | Interrupt number for a query |
| rsp_edge | output | 1 | Trigger type for a query, 1 = edge |

## Verification
The bench targets the following corner cases, each with the failure a faulty design would show:
- **Pool boundary.** A grant that ends exactly on `IRQ_LIMIT` must succeed and one a single vector beyond it must fail. A wrong comparison shows up as an off-by-one grant or refusal.
- **Failed grant.** After a refused grant, a query for the same function must report no entry. A design that writes the slot before checking the pool would answer with a bogus base.
- **Release and reuse.** A release must leave the entry in place. A re-request with a different count must be refused while the same count is re-confirmed without using pool space. Any mistake here moves the base numbers of every later entry.
- **Full table, wrapping sequence, bad inputs.** The bench also fills every slot, wraps the sequence number, and mixes in unknown function codes, foreign buses and absent functions. Throughout, it stalls `rsp_ready` so a response that changes while held is caught.

// File: rtl/msi_tbl_pkg.sv
package msi_tbl_pkg;
  localparam logic [3:0] ST_OK    = 4'h0;
  localparam logic [3:0] ST_HWERR = 4'hF;
  localparam logic [3:0] ST_PARAM = 4'hD;

  localparam logic [3:0] FN_MSI_A = 4'd1;
  localparam logic [3:0] FN_MSI_B = 4'd3;
  localparam logic [3:0] FN_MSIX  = 4'd4;

  localparam logic [1:0] IT_NONE  = 2'd0;
  localparam logic [1:0] IT_MSI   = 2'd1;
  localparam logic [1:0] IT_MSIX  = 2'd2;

  typedef enum logic {OP_CHANGE = 1'b0, OP_QUERY = 1'b1} msi_op_e;
endpackage

// File: rtl/msi_tbl_search.sv
module msi_tbl_search #(
  parameter int N      = 8,
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 6,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0][ADDR_W-1:0] ent_addr,
  input  logic [N-1:0][CNT_W-1:0]  ent_cnt,
  input  logic [ADDR_W-1:0]        key,
  output logic                     hit,
  output logic [IDX_W-1:0]         hit_idx,
  output logic                     free_ok,
  output logic [IDX_W-1:0]         free_idx
);
  logic done;

  always_comb begin
    hit      = 1'b0;
    hit_idx  = '0;
    free_ok  = 1'b0;
    free_idx = '0;
    done     = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!done) begin
        if (ent_cnt[i] == '0) begin
          free_ok  = 1'b1;
          free_idx = IDX_W'(i);
          done     = 1'b1;
        end else if (ent_addr[i] == key) begin
          hit     = 1'b1;
          hit_idx = IDX_W'(i);
          done    = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/msi_tbl_store.sv
module msi_tbl_store #(
  parameter int N      = 8,
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 6,
  parameter int IRQ_W  = 12,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [CNT_W-1:0]         wr_cnt,
  input  logic [IRQ_W-1:0]         wr_base,
  output logic [N-1:0][ADDR_W-1:0] ent_addr,
  output logic [N-1:0][CNT_W-1:0]  ent_cnt,
  output logic [N-1:0][IRQ_W-1:0]  ent_base
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_addr[g] <= '0;
        ent_cnt[g]  <= '0;
        ent_base[g] <= '0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        ent_addr[g] <= wr_addr;
        ent_cnt[g]  <= wr_cnt;
        ent_base[g] <= wr_base;
      end
    end

    // R3: an occupied slot is never cleared or rewritten
    a_r3_slot_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_cnt[g] != '0) |=> ($stable(ent_cnt[g]) && $stable(ent_addr[g]) && $stable(ent_base[g])));

    if (g > 0) begin : g_prefix
      // R2: used slots form a prefix of the table
      a_r2_used_prefix: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_cnt[g] != '0) |-> (ent_cnt[g-1] != '0));
    end
  end
endmodule

// File: rtl/msi_irq_pool.sv
module msi_irq_pool #(
  parameter int IRQ_W     = 12,
  parameter int CNT_W     = 6,
  parameter int IRQ_START = 256,
  parameter int IRQ_LIMIT = 320,
  localparam int NW = IRQ_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] want,
  input  logic             take,
  output logic             fits,
  output logic [IRQ_W-1:0] base
);
  logic [NW-1:0] next_q;
  logic [NW-1:0] after;

  assign after = next_q + NW'(want);
  assign fits  = (after <= NW'(IRQ_LIMIT));
  assign base  = next_q[IRQ_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)            next_q <= NW'(IRQ_START);
    else if (take && fits) next_q <= after;
  end

  // R6: the pool never runs past its limit nor below its start
  a_r6_pool_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (next_q <= NW'(IRQ_LIMIT)) && (next_q >= NW'(IRQ_START)));

  // R6: the pool only moves on a granted take
  a_r6_pool_still: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && fits) |=> $stable(next_q));
endmodule

// File: rtl/msi_vec_table.sv
module msi_vec_table
  import msi_tbl_pkg::*;
#(
  parameter int N         = 8,
  parameter int ADDR_W    = 24,
  parameter int CNT_W     = 6,
  parameter int IRQ_W     = 12,
  parameter int SEQ_W     = 16,
  parameter int VEC_W     = 6,
  parameter int BUS_W     = 16,
  parameter int OWN_BUS   = 'hA5,
  parameter int IRQ_START = 256,
  parameter int IRQ_LIMIT = 320
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_op,
  input  logic [3:0]        req_func,
  input  logic [BUS_W-1:0]  req_bus,
  input  logic              req_dev_ok,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_count,
  input  logic [SEQ_W-1:0]  req_seq,
  input  logic [VEC_W-1:0]  req_vec,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [3:0]        rsp_status,
  output logic [CNT_W-1:0]  rsp_count,
  output logic [SEQ_W-1:0]  rsp_seq,
  output logic [1:0]        rsp_itype,
  output logic [IRQ_W-1:0]  rsp_irq,
  output logic              rsp_edge
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0][ADDR_W-1:0] ent_addr;
  logic [N-1:0][CNT_W-1:0]  ent_cnt;
  logic [N-1:0][IRQ_W-1:0]  ent_base;
  logic                     hit, free_ok, fits;
  logic [IDX_W-1:0]         hit_idx, free_idx;
  logic [IRQ_W-1:0]         pool_base;
  logic                     accept, grow;

  logic [3:0]       d_status;
  logic [CNT_W-1:0] d_count;
  logic [SEQ_W-1:0] d_seq;
  logic [1:0]       d_itype;
  logic [IRQ_W-1:0] d_irq;
  logic             d_edge;
  logic [1:0]       fn_type;
  logic             bus_ok;

  assign req_ready = !rsp_valid;
  assign accept    = req_valid && req_ready;
  assign bus_ok    = (req_bus == BUS_W'(OWN_BUS));

  msi_tbl_search #(.N(N), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_search (
    .ent_addr(ent_addr), .ent_cnt(ent_cnt), .key(req_addr),
    .hit(hit), .hit_idx(hit_idx), .free_ok(free_ok), .free_idx(free_idx)
  );

  msi_irq_pool #(.IRQ_W(IRQ_W), .CNT_W(CNT_W), .IRQ_START(IRQ_START),
                 .IRQ_LIMIT(IRQ_LIMIT)) u_pool (
    .clk(clk), .rst_n(rst_n), .want(req_count), .take(accept && grow),
    .fits(fits), .base(pool_base)
  );

  msi_tbl_store #(.N(N), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .IRQ_W(IRQ_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(accept && grow && fits), .wr_idx(free_idx),
    .wr_addr(req_addr), .wr_cnt(req_count), .wr_base(pool_base),
    .ent_addr(ent_addr), .ent_cnt(ent_cnt), .ent_base(ent_base)
  );

  always_comb begin
    unique case (req_func)
      FN_MSI_A, FN_MSI_B: fn_type = IT_MSI;
      FN_MSIX:            fn_type = IT_MSIX;
      default:            fn_type = IT_NONE;
    endcase
  end

  always_comb begin
    d_status = ST_OK;
    d_count  = '0;
    d_seq    = '0;
    d_itype  = IT_NONE;
    d_irq    = '0;
    d_edge   = 1'b0;
    grow     = 1'b0;
    if (msi_op_e'(req_op) == OP_QUERY) begin
      if (!bus_ok) d_status = ST_PARAM;
      else if (!hit) d_status = ST_HWERR;
      else begin
        d_irq  = ent_base[hit_idx] + IRQ_W'(req_vec);
        d_edge = 1'b1;
      end
    end else if (fn_type == IT_NONE || !bus_ok || !req_dev_ok) begin
      d_status = ST_PARAM;
    end else if (req_count == '0) begin
      if (!hit) d_status = ST_HWERR;
    end else if (hit && ent_cnt[hit_idx] != req_count) begin
      d_status = ST_HWERR;
    end else if (!hit && !free_ok) begin
      d_status = ST_HWERR;
    end else begin
      grow = !hit;
      if (!hit && !fits) d_status = ST_HWERR;
      else begin
        d_count = req_count;
        d_seq   = req_seq + SEQ_W'(1);
        d_itype = fn_type;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_status <= ST_OK;
      rsp_count  <= '0;
      rsp_seq    <= '0;
      rsp_itype  <= IT_NONE;
      rsp_irq    <= '0;
      rsp_edge   <= 1'b0;
    end else if (accept) begin
      rsp_valid  <= 1'b1;
      rsp_status <= d_status;
      rsp_count  <= d_count;
      rsp_seq    <= d_seq;
      rsp_itype  <= d_itype;
      rsp_irq    <= d_irq;
      rsp_edge   <= d_edge;
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end

  // R11: a held response does not change or vanish
  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_status) && $stable(rsp_count)
      && $stable(rsp_seq) && $stable(rsp_itype) && $stable(rsp_irq) && $stable(rsp_edge)));

  // R11: acceptance produces a response on the next cycle
  a_r11_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);

  // R5: a failing response carries no payload
  a_r5_err_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status != ST_OK) |-> (rsp_count == '0 && rsp_itype == IT_NONE
      && rsp_irq == '0 && !rsp_edge));

  // R8: only queries report an edge trigger; never alongside a type
  a_r8_edge_excl: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_edge) |-> (rsp_itype == IT_NONE && rsp_status == ST_OK));
endmodule

// File: tb/test_msi_vec_table.sv
module test_msi_vec_table;
  localparam int N = 8, OWN = 'hA5, START = 256, LIMIT = 320;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready, req_op = 1'b0, req_dev_ok = 1'b0;
  logic [3:0]  req_func = '0;
  logic [15:0] req_bus = '0;
  logic [23:0] req_addr = '0;
  logic [5:0]  req_count = '0, req_vec = '0;
  logic [15:0] req_seq = '0;
  logic        rsp_valid, rsp_ready = 1'b1, rsp_edge;
  logic [3:0]  rsp_status;
  logic [5:0]  rsp_count;
  logic [15:0] rsp_seq;
  logic [1:0]  rsp_itype;
  logic [11:0] rsp_irq;

  always #2 clk = ~clk;

  msi_vec_table i_msi_vec_table (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_func(req_func), .req_bus(req_bus), .req_dev_ok(req_dev_ok),
    .req_addr(req_addr), .req_count(req_count), .req_seq(req_seq), .req_vec(req_vec),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
    .rsp_count(rsp_count), .rsp_seq(rsp_seq), .rsp_itype(rsp_itype),
    .rsp_irq(rsp_irq), .rsp_edge(rsp_edge)
  );

  typedef struct {
    logic [3:0] st; int cnt; int seq; int ity; int irq; int edg; string tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  int m_addr[N], m_cnt[N], m_base[N];
  int m_next = START;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 rsp_ready <= (cyc % 5) != 2;
  end

  task automatic send(input bit op, input int fn, input int bus, input bit dok,
                      input int addr, input int cnt, input int seq, input int vec,
                      input string tag);
    exp_t e;
    int hit = -1, fr = -1, ity = 0;
    e = '{st: 4'h0, cnt: 0, seq: 0, ity: 0, irq: 0, edg: 0, tag: tag};
    for (int i = 0; i < N; i++) begin
      if (m_cnt[i] == 0) begin fr = i; break; end
      if (m_addr[i] == addr) begin hit = i; break; end
    end
    if (fn == 1 || fn == 3) ity = 1; else if (fn == 4) ity = 2;
    if (op) begin
      if (bus != OWN) e.st = 4'hD;
      else if (hit < 0) e.st = 4'hF;
      else begin e.irq = (m_base[hit] + vec) & 12'hFFF; e.edg = 1; end
    end else if (ity == 0 || bus != OWN || !dok) e.st = 4'hD;
    else if (cnt == 0) begin
      if (hit < 0) e.st = 4'hF;
    end else if (hit >= 0 && m_cnt[hit] != cnt) e.st = 4'hF;
    else if (hit < 0 && (fr < 0 || m_next + cnt > LIMIT)) e.st = 4'hF;
    else begin
      if (hit < 0) begin
        m_addr[fr] = addr; m_cnt[fr] = cnt; m_base[fr] = m_next; m_next += cnt;
      end
      e.cnt = cnt; e.seq = (seq + 1) & 16'hFFFF; e.ity = ity;
    end
    q.push_back(e);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_op = op; req_func = 4'(fn); req_bus = 16'(bus); req_dev_ok = dok;
    req_addr = 24'(addr); req_count = 6'(cnt); req_seq = 16'(seq); req_vec = 6'(vec);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  bit held = 0;
  logic [3:0] h_st; logic [5:0] h_cnt; logic [15:0] h_seq; logic [11:0] h_irq;
  always @(negedge clk) begin
    if (rst_n) begin
      if (held) begin
        checks++;
        if (!rsp_valid || rsp_status != h_st || rsp_count != h_cnt || rsp_seq != h_seq
            || rsp_irq != h_irq) begin
          fails++;
          $display("FAIL R11 held response changed: got v=%0d st=%h cnt=%0d, expected v=1 st=%h cnt=%0d",
                   rsp_valid, rsp_status, rsp_count, h_st, h_cnt);
        end
      end
      held = rsp_valid && !rsp_ready;
      h_st = rsp_status; h_cnt = rsp_count; h_seq = rsp_seq; h_irq = rsp_irq;
      if (rsp_valid && rsp_ready) begin
        checks++;
        if (q.size() == 0) begin
          fails++;
          $display("FAIL R11 unexpected response: got st=%h, expected none", rsp_status);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (rsp_status != e.st || int'(rsp_count) != e.cnt || int'(rsp_seq) != e.seq
              || int'(rsp_itype) != e.ity || int'(rsp_irq) != e.irq || int'(rsp_edge) != e.edg) begin
            fails++;
            $display("FAIL %s: got st=%h cnt=%0d seq=%0d ty=%0d irq=%0d edge=%0d, expected st=%h cnt=%0d seq=%0d ty=%0d irq=%0d edge=%0d",
                     e.tag, rsp_status, rsp_count, rsp_seq, rsp_itype, rsp_irq, rsp_edge,
                     e.st, e.cnt, e.seq, e.ity, e.irq, e.edg);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_addr[i] = 0; m_cnt[i] = 0; m_base[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || req_ready !== 1'b1) begin
      fails++;
      $display("FAIL R1 reset: got valid=%b ready=%b, expected valid=0 ready=1", rsp_valid, req_ready);
    end
    // R9: nothing known yet
    send(1, 0, OWN, 1, 'h100, 0, 0, 0, "R9 query empty table");
    send(0, 1, OWN, 1, 'h100, 0, 0, 0, "R9 release without entry");
    // R4 / R10: parameter errors
    send(0, 2, OWN, 1, 'h100, 4, 1, 0, "R4 func 2 rejected");
    send(0, 0, OWN, 1, 'h100, 4, 1, 0, "R4 func 0 rejected");
    send(0, 1, 'h11, 1, 'h100, 4, 1, 0, "R10 foreign bus change");
    send(0, 1, OWN, 0, 'h100, 4, 1, 0, "R10 absent device");
    send(1, 0, 'h11, 1, 'h100, 0, 0, 0, "R10 foreign bus query");
    // R1 / R5: first grant at IRQ_START
    send(0, 1, OWN, 1, 'h100, 4, 7, 0, "R1 R5 first MSI grant");
    send(0, 4, OWN, 1, 'h200, 2, 'hFFFF, 0, "R5 MSI-X grant with seq wrap");
    send(1, 0, OWN, 0, 'h200, 0, 0, 1, "R8 R10 query ignores dev_ok");
    send(1, 0, OWN, 1, 'h100, 0, 0, 3, "R8 query first entry");
    // R7: reuse
    send(0, 3, OWN, 1, 'h100, 4, 20, 0, "R7 same count reuse");
    send(0, 1, OWN, 1, 'h100, 3, 21, 0, "R7 count mismatch");
    // R3: release keeps entry
    send(0, 1, OWN, 1, 'h100, 0, 22, 0, "R3 release");
    send(1, 0, OWN, 1, 'h100, 0, 0, 2, "R3 entry kept after release");
    // R6: pool
    send(0, 1, OWN, 1, 'h300, 59, 30, 0, "R6 grant past limit");
    send(1, 0, OWN, 1, 'h300, 0, 0, 0, "R6 no entry after refusal");
    send(0, 1, OWN, 1, 'h300, 53, 31, 0, "R6 large grant");
    send(0, 1, OWN, 1, 'h301, 1, 32, 0, "R2 fill slot 3");
    send(0, 1, OWN, 1, 'h302, 1, 33, 0, "R2 fill slot 4");
    send(0, 4, OWN, 1, 'h303, 1, 34, 0, "R2 fill slot 5");
    send(0, 1, OWN, 1, 'h304, 1, 35, 0, "R2 fill slot 6");
    send(0, 1, OWN, 1, 'h305, 2, 36, 0, "R6 one past limit");
    send(0, 1, OWN, 1, 'h305, 1, 37, 0, "R6 exactly at limit");
    send(0, 1, OWN, 1, 'h306, 1, 38, 0, "R9 table full");
    send(1, 0, OWN, 1, 'h305, 0, 0, 0, "R2 R8 query last slot");
    send(1, 0, OWN, 1, 'h302, 0, 0, 0, "R2 R8 query middle slot");
    send(0, 4, OWN, 1, 'h200, 2, 40, 0, "R7 reuse when full");
    repeat (20) @(negedge clk);
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R11 missing responses: got %0d pending, expected 0", q.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule